// File: doc/BRIEF.md
# Reset, Strap and Power-State Controller

This block governs how a multichannel PWM amplifier controller comes out of reset and enters operation. An asynchronous active-low reset input clears every internal flop immediately. Its release is retimed to the master clock before anything else acts on it. While reset is active, the control port is held in reset and every PWM output is clamped low.

On the first master-clock edge after the retimed release, the level of the mute strap pin is captured. That captured bit fixes the system clock output until the next reset. A low strap passes the master clock straight through. A high strap produces the master clock divided by two, with an even duty cycle. Later changes on the pin do nothing.

After release the device waits in a low-power state with its power-down bit set. A control write that clears the bit moves it to the running state, and a write that sets the bit moves it back. A status output reports when the device is running.

Top module: `pwr_strap_ctrl`

FSM states: `ST_RESET` (in reset), `ST_LOWPWR` (control port live, channels off), `ST_RUN` (channels enabled). Transitions:
- `REL`: `ST_RESET`→`ST_LOWPWR` on the edge after the retimed release; the strap is captured on this edge.
- `WAKE`: `ST_LOWPWR`→`ST_RUN` when the power-down bit reads 0.
- `SLEEP`: `ST_RUN`→`ST_LOWPWR` when the power-down bit reads 1.
- `ABORT`: any state→`ST_RESET` asynchronously while reset is low.

## Requirements
- R1: While `rst_n_async` is low, every flop is cleared at once, without waiting for a clock edge. In that condition `ctl_rst_n`=0, `pdn`=1, `running`=0, `pwm_en`=0 and `sys_clk`=0.
- R2: `pwm_clamp` is 1 whenever the FSM is in `ST_RESET`, and 0 in the other states.
- R3: Reset release passes through a two-flop synchroniser. `ctl_rst_n` rises on the third rising `mclk` edge after `rst_n_async` goes high.
- R4: The strap level sampled on the `REL` edge is the captured divider select. It has no effect before that edge.
- R5: With a captured select of 0, `sys_clk` equals `mclk`. Before capture, `sys_clk` is 0.
- R6: With a captured select of 1, `sys_clk` is a toggle flop that starts low at capture and inverts on every `mclk` rising edge. This gives a period of two `mclk` cycles at 50% duty.
- R7: After capture, changes on `mute_strap` do not alter `sys_clk` until the next reset.
- R8: `pdn` resets to 1. On an `mclk` edge with `pdn_wr_en`=1 outside `ST_RESET`, `pdn` takes the value of `pdn_wr_data`.
- R9: The FSM moves to `ST_RUN` on the edge after `pdn` reads 0, and back to `ST_LOWPWR` on the edge after `pdn` reads 1.
- R10: A write presented on an edge where the FSM is still in `ST_RESET` is ignored. This includes the `REL` edge itself.
- R11: `running` and `pwm_en` are 1 exactly in `ST_RUN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n_async | input | 1 | Asynchronous active-low reset |
| mute_strap | input | 1 | Strap pin selecting the clock divider |
| pdn_wr_en | input | 1 | Power-down bit write strobe |
| pdn_wr_data | input | 1 | Value written to the power-down bit |
| sys_clk | output | 1 | System clock output |
| ctl_rst_n | output | 1 | Active-low reset for the control port |
| pwm_clamp | output | 1 | Forces all PWM outputs low |
| pwm_en | output | 1 | Enables the PWM channels |
| pdn | output | 1 | Current power-down bit |
| running | output | 1 | Device is in normal operation |

## Verification
Two events can land on the same clock edge: the `REL` edge that captures the strap, and a power-down write that the control logic would accept one edge later. The bench raises `pdn_wr_en` with data 0 across exactly the `REL` edge. It then checks every clock that `pdn` stays 1 and `running` stays 0, while the divider select is still taken from the strap on that edge. A second collision asserts reset in the middle of a cycle that also carries a write. The test expects the clear to win at once.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
    typedef enum logic [1:0] {
        ST_RESET  = 2'd0,
        ST_LOWPWR = 2'd1,
        ST_RUN    = 2'd2
    } pwr_state_t;
endpackage

// File: rtl/rst_retime.sv
module rst_retime #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_stb,
    input  logic strap_in,
    output logic cap_valid,
    output logic sel_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            sel_q     <= 1'b0;
        end else if (cap_stb && !cap_valid) begin
            cap_valid <= 1'b1;
            sel_q     <= strap_in;
        end
    end
endmodule

// File: rtl/clk_out_sel.sv
module clk_out_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic div2,
    output logic clk_out,
    output logic half_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          half_q <= 1'b0;
        else if (en && div2) half_q <= ~half_q;
    end

    assign clk_out = en ? (div2 ? half_q : clk) : 1'b0;
endmodule

// File: rtl/pwr_strap_ctrl.sv
module pwr_strap_ctrl
    import pwr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic mclk,
    input  logic rst_n_async,
    input  logic mute_strap,
    input  logic pdn_wr_en,
    input  logic pdn_wr_data,
    output logic sys_clk,
    output logic ctl_rst_n,
    output logic pwm_clamp,
    output logic pwm_en,
    output logic pdn,
    output logic running
);
    pwr_state_t state_q, state_d;
    logic       rst_n_sync;
    logic       cap_valid;
    logic       div_sel;
    logic       half_q;
    logic       cap_stb;
    logic       pdn_q;

    rst_retime #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (mclk),
        .arst_n     (rst_n_async),
        .rst_n_sync (rst_n_sync)
    );

    strap_capture u_strap (
        .clk       (mclk),
        .rst_n     (rst_n_sync),
        .cap_stb   (cap_stb),
        .strap_in  (mute_strap),
        .cap_valid (cap_valid),
        .sel_q     (div_sel)
    );

    clk_out_sel u_clk (
        .clk     (mclk),
        .rst_n   (rst_n_sync),
        .en      (cap_valid),
        .div2    (div_sel),
        .clk_out (sys_clk),
        .half_q  (half_q)
    );

    // Power-down bit: writable only once out of ST_RESET
    always_ff @(posedge mclk or negedge rst_n_sync) begin
        if (!rst_n_sync)                         pdn_q <= 1'b1;
        else if (pdn_wr_en && state_q != ST_RESET) pdn_q <= pdn_wr_data;
    end

    // State register
    always_ff @(posedge mclk or negedge rst_n_sync) begin
        if (!rst_n_sync) state_q <= ST_RESET;
        else             state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET:  state_d = ST_LOWPWR;
            ST_LOWPWR: if (!pdn_q) state_d = ST_RUN;
            ST_RUN:    if (pdn_q)  state_d = ST_LOWPWR;
            default:   state_d = ST_RESET;
        endcase
    end

    // Outputs
    always_comb begin
        ctl_rst_n = 1'b0;
        pwm_clamp = 1'b1;
        pwm_en    = 1'b0;
        cap_stb   = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                cap_stb = 1'b1;
            end
            ST_LOWPWR: begin
                ctl_rst_n = 1'b1;
                pwm_clamp = 1'b0;
            end
            ST_RUN: begin
                ctl_rst_n = 1'b1;
                pwm_clamp = 1'b0;
                pwm_en    = 1'b1;
            end
            default: begin
                ctl_rst_n = 1'b0;
            end
        endcase
    end

    assign running = pwm_en;
    assign pdn     = pdn_q;
endmodule

// File: rtl/pwr_strap_ctrl_chk.sv
module pwr_strap_ctrl_chk (
    input logic mclk,
    input logic rst_n_async,
    input logic mute_strap,
    input logic ctl_rst_n,
    input logic pwm_clamp,
    input logic pwm_en,
    input logic pdn,
    input logic running,
    input logic div_sel,
    input logic half_q
);
    // R9
    run_needs_pdn_low_chk: assert property (@(posedge mclk) disable iff (!rst_n_async)
        $rose(running) |-> $past(!pdn));

    // R10
    no_write_in_reset_chk: assert property (@(posedge mclk) disable iff (!rst_n_async)
        !ctl_rst_n |=> pdn);

    // R4
    strap_capture_chk: assert property (@(posedge mclk) disable iff (!rst_n_async)
        $rose(ctl_rst_n) |-> (div_sel == $past(mute_strap)));

    // R7
    strap_hold_chk: assert property (@(posedge mclk) disable iff (!rst_n_async)
        (ctl_rst_n && $past(ctl_rst_n)) |-> $stable(div_sel));

    // R6
    half_toggle_chk: assert property (@(posedge mclk) disable iff (!rst_n_async)
        (div_sel && ctl_rst_n && $past(ctl_rst_n)) |-> (half_q != $past(half_q)));

    // R11
    run_flags_chk: assert property (@(posedge mclk) disable iff (!rst_n_async)
        running |-> (pwm_en && !pwm_clamp && ctl_rst_n));

    // R2
    clamp_excl_chk: assert property (@(posedge mclk) disable iff (!rst_n_async)
        pwm_clamp |-> (!ctl_rst_n && !running));
endmodule

bind pwr_strap_ctrl pwr_strap_ctrl_chk u_chk (
    .mclk        (mclk),
    .rst_n_async (rst_n_async),
    .mute_strap  (mute_strap),
    .ctl_rst_n   (ctl_rst_n),
    .pwm_clamp   (pwm_clamp),
    .pwm_en      (pwm_en),
    .pdn         (pdn),
    .running     (running),
    .div_sel     (div_sel),
    .half_q      (half_q)
);

// File: tb/pwr_strap_ctrl_test.sv
`timescale 1ns/100ps
module pwr_strap_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mute = 1'b0;
    logic wr_en = 1'b0;
    logic wr_data = 1'b0;
    logic sys_clk, ctl_rst_n, pwm_clamp, pwm_en, pdn, running;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pwr_strap_ctrl uut (
        .mclk        (clk),
        .rst_n_async (rst_n),
        .mute_strap  (mute),
        .pdn_wr_en   (wr_en),
        .pdn_wr_data (wr_data),
        .sys_clk     (sys_clk),
        .ctl_rst_n   (ctl_rst_n),
        .pwm_clamp   (pwm_clamp),
        .pwm_en      (pwm_en),
        .pdn         (pdn),
        .running     (running)
    );

    // Behavioural reference: edge counter since release, mode flags
    int m_rel;      // edges seen since reset release
    int m_state;    // 0 reset, 1 low power, 2 run
    bit m_pdn, m_cap, m_div, m_half;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_rel = 0; m_state = 0; m_pdn = 1; m_cap = 0; m_div = 0; m_half = 0;
        end else begin
            int o_rel, o_state;
            bit o_pdn, o_cap, o_div, o_half;
            o_rel = m_rel; o_state = m_state; o_pdn = m_pdn;
            o_cap = m_cap; o_div = m_div; o_half = m_half;
            if (m_rel < 10) m_rel = m_rel + 1;
            if (o_cap && o_div) m_half = !o_half;
            if (o_state == 0) begin
                if (o_rel >= 2) begin          // R3 retimed release, R4 capture
                    m_state = 1; m_cap = 1; m_div = mute;
                end
            end else begin
                if (wr_en) m_pdn = wr_data;    // R8, R10
                m_state = o_pdn ? 1 : 2;       // R9
            end
        end
    end

    task automatic chk(string req, logic got, logic exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s t=%0t got=%b exp=%b", req, $time, got, exp);
        end
    endtask

    // Compare away from both edges
    always @(posedge clk) begin
        #1.5;
        if (!done) begin
            chk("R1/R3 ctl_rst_n", ctl_rst_n, m_state != 0);
            chk("R2 pwm_clamp",   pwm_clamp, m_state == 0);
            chk("R8 pdn",         pdn,       m_pdn);
            chk("R11 running",    running,   m_state == 2);
            chk("R11 pwm_en",     pwm_en,    m_state == 2);
            chk("R5/R6 sys_clk hi", sys_clk, m_cap ? (m_div ? m_half : 1'b1) : 1'b0);
        end
    end
    always @(negedge clk) begin
        #1.5;
        if (!done)
            chk("R5/R6/R7 sys_clk lo", sys_clk, m_cap ? (m_div ? m_half : 1'b0) : 1'b0);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic d);
        wr_en = 1'b1; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    initial begin
        // R1 reset state, divide strap high
        mute = 1'b1;
        step(5);
        rst_n = 1'b1;                 // release after edge 0
        step(2);                       // edges 1,2 passed: R3 still in reset
        // R10: write across the REL edge (edge 3) is ignored
        wr_en = 1'b1; wr_data = 1'b0;
        step(1);
        wr_en = 1'b0;
        step(6);                       // R6 divide-by-two running, R9 stays low power
        mute = 1'b0;                   // R7 strap change ignored
        step(6);
        wr(1'b0);                      // R8 clear pdn, R9 WAKE, R11 running
        step(8);
        wr(1'b1);                      // R9 SLEEP
        step(5);
        wr(1'b0);
        step(4);
        // R1: reset in the same cycle as a write
        wr_en = 1'b1; wr_data = 1'b1;
        #0.5 rst_n = 1'b0;
        step(1);
        wr_en = 1'b0;
        step(3);
        // R5: strap low selects mclk pass-through
        mute = 1'b0;
        rst_n = 1'b1;
        step(4);
        mute = 1'b1;                   // R7 ignored after capture
        step(4);
        wr(1'b0);                      // R9 WAKE again
        step(6);
        wr(1'b1);
        step(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule